// File: doc/BRIEF.md
# Pulse-Position Preamble Detector

The block sits behind a threshold slicer and watches its one-bit output at the full sample rate. Each clock it takes one binary sample into a history register that spans one preamble window. In every cycle it compares that window with a fixed sparse pulse-position template and counts the samples that disagree. When the disagreement count is within a tolerance, the block declares a preamble.

A declared preamble has three effects in the same cycle. It sends a single-cycle start-of-frame strobe to the timing-recovery stage. It sends a single-cycle reset to the frame assembler, so the next frame starts at bit zero. It also triggers a pulse stretcher that holds an indicator output high long enough for a person to see it.

After each detection a lockout window blocks further detections, so the frame payload that follows cannot retrigger the search. A reset clears the history. No match can then be reported until a whole new window of samples has arrived.

Top module: `preamble_detector`

## Requirements
- R1: While `rst_ni` is low and directly after it is released, `sof_o`, `frame_rst_o` and `led_o` are low.
- R2: Sample k of the window is the k-th of the last 128 samples taken, where k = 0 is the oldest. The template is high for samples 0..7, 16..23, 56..63 and 72..79, and low for the other 128-sample positions. When the window matches exactly, `sof_o` is high in the cycle after the clock edge that captured the last sample.
- R3: A detection is declared when the count of window samples that differ from the template is at most MATCH_TOL (default 4). With MATCH_TOL+1 differences, or with the whole pattern shifted by one sample (8 differences), no detection is declared.
- R4: `sof_o` is exactly one cycle wide. `frame_rst_o` is high in exactly the same cycles as `sof_o`.
- R5: After a detection in cycle D, no detection is reported in cycles D+1 through D+LOCKOUT (default 1792). A matching window that completes in cycle D+LOCKOUT+1 or later is reported.
- R6: After a detection in cycle D, `led_o` is high from cycle D+1 through D+LED_CYCLES (default 4096) and low in the cycle after that, unless a new detection retriggers it.
- R7: Reset clears the sample history and the lockout. In the cycle after a matching window completes, a detection is reported only if at least 128 samples have been captured since reset. A preamble that is cut by a reset is therefore not reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock, one sample per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sample_i | input | 1 | Sliced binary sample |
| sof_o | output | 1 | Start-of-frame strobe to timing recovery |
| frame_rst_o | output | 1 | Reset strobe to the frame assembler |
| led_o | output | 1 | Stretched detection indicator |

## Verification
Two situations are hard to reach from the pins. The first is the exact edge of the lockout window: a second preamble has to complete in precisely cycle D+LOCKOUT, and another in D+LOCKOUT+1. The stimulus counts the idle samples after a detection so that the last template sample lands in each of those two cycles. The second is a reset that cuts a preamble one sample before it completes: 127 template samples go in, the reset is pulsed, and the final sample follows on release. Tolerance corners come from a table of flip masks XORed onto the template.

// File: rtl/preamble_pkg.sv
package preamble_pkg;

  // true when window index k (0 = oldest) falls inside one of the four pulses
  function automatic bit in_pulse(int k, int plen, int o0, int o1, int o2, int o3);
    return (k >= o0 && k < o0 + plen) || (k >= o1 && k < o1 + plen) ||
           (k >= o2 && k < o2 + plen) || (k >= o3 && k < o3 + plen);
  endfunction

endpackage

// File: rtl/sample_history.sv
module sample_history #(
  parameter int WIN_LEN = 128
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sample_i,
  output logic [WIN_LEN-1:0] hist_o,
  output logic               full_o
);
  localparam int CW = $clog2(WIN_LEN + 1);

  logic [WIN_LEN-1:0] hist_q;
  logic [CW-1:0]      fill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      fill_q <= '0;
    end else begin
      hist_q <= {hist_q[WIN_LEN-2:0], sample_i};
      if (fill_q != CW'(WIN_LEN)) fill_q <= fill_q + 1'b1;
    end
  end

  assign hist_o = hist_q;
  assign full_o = (fill_q == CW'(WIN_LEN));
endmodule

// File: rtl/template_matcher.sv
module template_matcher #(
  parameter int WIN_LEN    = 128,
  parameter int PULSE_LEN  = 8,
  parameter int PULSE_OFS0 = 0,
  parameter int PULSE_OFS1 = 16,
  parameter int PULSE_OFS2 = 56,
  parameter int PULSE_OFS3 = 72,
  parameter int MATCH_TOL  = 4
) (
  input  logic [WIN_LEN-1:0] hist_i,
  output logic               hit_o
);
  localparam int CW = $clog2(WIN_LEN + 1);

  logic [WIN_LEN-1:0] tmpl;
  logic [WIN_LEN-1:0] diff;
  logic [CW-1:0]      miss_cnt;

  // oldest sample sits in the MSB of the history
  for (genvar k = 0; k < WIN_LEN; k++) begin : g_tmpl
    assign tmpl[WIN_LEN-1-k] = preamble_pkg::in_pulse(k, PULSE_LEN, PULSE_OFS0,
                                                      PULSE_OFS1, PULSE_OFS2, PULSE_OFS3);
  end

  assign diff = hist_i ^ tmpl;

  always_comb begin
    miss_cnt = '0;
    for (int i = 0; i < WIN_LEN; i++) miss_cnt = miss_cnt + CW'(diff[i]);
  end

  assign hit_o = (miss_cnt <= CW'(MATCH_TOL));
endmodule

// File: rtl/lockout_gate.sv
module lockout_gate #(
  parameter int LOCKOUT = 1792
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cand_i,
  output logic fire_o
);
  localparam int LW = $clog2(LOCKOUT + 1);

  logic [LW-1:0] lock_q;

  assign fire_o = cand_i && (lock_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             lock_q <= '0;
    else if (fire_o)         lock_q <= LW'(LOCKOUT);
    else if (lock_q != '0)   lock_q <= lock_q - 1'b1;
  end
endmodule

// File: rtl/pulse_stretcher.sv
module pulse_stretcher #(
  parameter int LED_CYCLES = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic led_o
);
  localparam int SW = $clog2(LED_CYCLES + 1);

  logic [SW-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            hold_q <= '0;
    else if (trig_i)        hold_q <= SW'(LED_CYCLES);
    else if (hold_q != '0)  hold_q <= hold_q - 1'b1;
  end

  assign led_o = (hold_q != '0);
endmodule

// File: rtl/preamble_detector.sv
module preamble_detector #(
  parameter int WIN_LEN    = 128,
  parameter int PULSE_LEN  = 8,
  parameter int PULSE_OFS0 = 0,
  parameter int PULSE_OFS1 = 16,
  parameter int PULSE_OFS2 = 56,
  parameter int PULSE_OFS3 = 72,
  parameter int MATCH_TOL  = 4,
  parameter int LOCKOUT    = 1792,
  parameter int LED_CYCLES = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sample_i,
  output logic sof_o,
  output logic frame_rst_o,
  output logic led_o
);
  logic [WIN_LEN-1:0] hist;
  logic               hist_full;
  logic               hit;
  logic               fire;

  sample_history #(.WIN_LEN(WIN_LEN)) u_hist (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sample_i(sample_i),
    .hist_o  (hist),
    .full_o  (hist_full)
  );

  template_matcher #(
    .WIN_LEN   (WIN_LEN),
    .PULSE_LEN (PULSE_LEN),
    .PULSE_OFS0(PULSE_OFS0),
    .PULSE_OFS1(PULSE_OFS1),
    .PULSE_OFS2(PULSE_OFS2),
    .PULSE_OFS3(PULSE_OFS3),
    .MATCH_TOL (MATCH_TOL)
  ) u_match (
    .hist_i(hist),
    .hit_o (hit)
  );

  lockout_gate #(.LOCKOUT(LOCKOUT)) u_lock (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cand_i(hit && hist_full),
    .fire_o(fire)
  );

  pulse_stretcher #(.LED_CYCLES(LED_CYCLES)) u_led (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .trig_i(fire),
    .led_o (led_o)
  );

  assign sof_o       = fire;
  assign frame_rst_o = fire;
endmodule

// File: rtl/preamble_detector_chk.sv
module preamble_detector_chk #(
  parameter int WIN_LEN = 128,
  parameter int LOCKOUT = 1792
) (
  input logic clk_i,
  input logic rst_ni,
  input logic sof_o,
  input logic led_o
);
  localparam int CW = $clog2(WIN_LEN + 1);
  localparam int GW = $clog2(LOCKOUT + 2);

  logic [CW-1:0] since_rst_q;
  logic [GW-1:0] gap_q;
  logic          seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_rst_q <= '0;
      gap_q       <= '0;
      seen_q      <= 1'b0;
    end else begin
      if (since_rst_q != CW'(WIN_LEN)) since_rst_q <= since_rst_q + 1'b1;
      if (sof_o) begin
        seen_q <= 1'b1;
        gap_q  <= GW'(1);
      end else if (seen_q && gap_q != GW'(LOCKOUT + 1)) begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  assert_idle_after_reset_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !led_o && !sof_o);

  assert_sof_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |=> !sof_o);

  assert_lockout_gap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sof_o && seen_q) |-> (gap_q > GW'(LOCKOUT)));

  assert_led_follows_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |=> led_o);

  assert_full_window_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> (since_rst_q == CW'(WIN_LEN)));
endmodule

bind preamble_detector preamble_detector_chk #(
  .WIN_LEN(WIN_LEN),
  .LOCKOUT(LOCKOUT)
) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .sof_o (sof_o),
  .led_o (led_o)
);

// File: tb/tb_preamble_detector.sv
module tb_preamble_detector;
  localparam int WIN     = 128;
  localparam int LOCKOUT = 1792;
  localparam int LED_CYC = 4096;

  // entry: {expect_detect, flip mask}; mask bit k flips window sample k (0 = oldest)
  localparam logic [WIN:0] VEC [6] = '{
    {1'b1, 128'h0},
    {1'b1, (128'(1) << 3)},
    {1'b1, (128'(1) << 0) | (128'(1) << 23) | (128'(1) << 60) | (128'(1) << 100)},
    {1'b0, (128'(1) << 0) | (128'(1) << 23) | (128'(1) << 60) | (128'(1) << 100) | (128'(1) << 127)},
    {1'b1, (128'(1) << 72) | (128'(1) << 73) | (128'(1) << 74) | (128'(1) << 75)},
    {1'b0, (128'(1) << 0) | (128'(1) << 8) | (128'(1) << 16) | (128'(1) << 24) |
           (128'(1) << 56) | (128'(1) << 64) | (128'(1) << 72) | (128'(1) << 80)}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sample_i = 1'b0;
  logic sof_o, frame_rst_o, led_o;
  int   n_chk = 0;
  int   n_fail = 0;
  logic [WIN-1:0] pre;

  always #2.5 clk = ~clk;

  preamble_detector #(.LOCKOUT(LOCKOUT), .LED_CYCLES(LED_CYC)) dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .sample_i   (sample_i),
    .sof_o      (sof_o),
    .frame_rst_o(frame_rst_o),
    .led_o      (led_o)
  );

  function automatic logic [WIN-1:0] make_pre();
    logic [WIN-1:0] p = '0;
    for (int k = 0; k < WIN; k++)
      p[k] = (k < 8) || (k >= 16 && k < 24) || (k >= 56 && k < 64) || (k >= 72 && k < 80);
    return p;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // one sample per cycle, driven at the falling edge
  task automatic feed(logic [WIN-1:0] pat, int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      sample_i = pat[k];
    end
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      sample_i = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    pre = make_pre();
    repeat (3) @(negedge clk);
    chk("R1 sof in reset", sof_o, 1'b0);
    chk("R1 frame_rst in reset", frame_rst_o, 1'b0);
    chk("R1 led in reset", led_o, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 led after release", led_o, 1'b0);

    // R2 / R3: tolerance table
    for (int i = 0; i < 6; i++) begin
      feed(pre ^ VEC[i][WIN-1:0], WIN);
      @(negedge clk);
      chk("R2 R3 table sof", sof_o, VEC[i][WIN]);
      chk("R4 table frame_rst", frame_rst_o, VEC[i][WIN]);
      idle(LOCKOUT);
    end

    // R4 width, R6 stretch
    feed(pre, WIN);
    @(negedge clk);
    chk("R4 sof high", sof_o, 1'b1);
    idle(1);
    chk("R4 sof one cycle", sof_o, 1'b0);
    chk("R4 frame_rst one cycle", frame_rst_o, 1'b0);
    chk("R6 led rises", led_o, 1'b1);
    idle(LED_CYC - 1);
    chk("R6 led last cycle", led_o, 1'b1);
    idle(1);
    chk("R6 led falls", led_o, 1'b0);

    // R5 lockout boundary: completion at D+LOCKOUT blocked, at D+LOCKOUT+1 allowed
    feed(pre, WIN);
    @(negedge clk);
    chk("R5 first detect", sof_o, 1'b1);
    idle(LOCKOUT - 1 - WIN);
    feed(pre, WIN);
    @(negedge clk);
    chk("R5 blocked at lockout end", sof_o, 1'b0);
    feed(pre, WIN);
    @(negedge clk);
    chk("R5 detect after lockout", sof_o, 1'b1);
    idle(LOCKOUT - WIN);
    feed(pre, WIN);
    @(negedge clk);
    chk("R5 detect at lockout+1", sof_o, 1'b1);
    idle(LOCKOUT);

    // R7: reset cuts a preamble one sample short
    feed(pre, WIN - 1);
    @(negedge clk);
    rst_ni = 1'b0;
    sample_i = 1'b0;
    @(negedge clk);
    chk("R7 led cleared by reset", led_o, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R7 no match across reset", sof_o, 1'b0);
    feed(pre, WIN);
    @(negedge clk);
    chk("R7 detect after fresh window", sof_o, 1'b1);
    idle(4);
    finish_run();
  end
endmodule